// File: doc/BRIEF.md
# Predicated Integer Compare and Execute Unit

This unit carries out integer add, subtract and compare operations under a qualifying predicate. Each operation selects one of the predicate bits held inside the unit. When that bit is 1 the result is committed. When it is 0 the operation becomes a no-op. Predicate 0 is hard-wired to 1, so an operation that needs no qualification simply selects it. A compiler can therefore issue both arms of an if/else as straight-line code, guarded by complementary predicates, and no branch is taken.

A compare evaluates one of four conditions on two 64-bit operands: equal, not equal, signed less-than or unsigned less-than. It writes the outcome to a first predicate destination and the complement of the outcome to a second. Add and subtract take either two register operands or a register and an immediate. They produce a general-register writeback request. Source values arrive from the general register file's read ports together with their indices. A source index of 0 always reads as zero.

Operations enter on a valid/ready port. `in_ready` is held high at all times, because every operation completes in a single cycle and the unit never applies back-pressure. A cycle with `in_valid` high is a transfer. Writeback requests appear one clock later. Predicate updates become visible in the same cycle as those requests, so the very next operation can be qualified by a predicate that the previous compare produced.

Top module: `pce_unit`

## Requirements
- R1: `in_ready` is always 1. An operation accepted in cycle t shows its writeback outputs in cycle t+1. A cycle with `in_valid` low produces no write enable in the following cycle.
- R2: Opcode 0 (add) and opcode 1 (subtract) compute src1+src2 or src1−src2 modulo 2^64. When `in_use_imm` is 1, `in_imm` replaces the second source. The result is written with `gr_we` to `gr_waddr` = `in_dst`.
- R3: A source whose index is 0 contributes zero, whatever value is on its value input.
- R4: An operation whose qualifying predicate reads 0 produces no writeback, and it leaves every predicate bit unchanged. This holds for compares too. Predicate 0 always reads 1.
- R5: A compare writes its condition to `in_pdst1` (`pr_we1`/`pr_wdata1`) and the inverse of the condition to `in_pdst2` (`pr_we2`/`pr_wdata2`).
- R6: Compare opcodes are 2 for equal, 3 for not equal, 4 for signed less-than and 5 for unsigned less-than. Each compares src1 against src2, or against the immediate when `in_use_imm` is 1.
- R7: When both predicate destinations name the same register, only the first destination is written, and it is written with the condition.
- R8: A writeback aimed at general register 0 or at predicate 0 is suppressed, and predicate 0 keeps its value of 1.
- R9: A predicate written by an operation accepted in cycle t already qualifies an operation accepted in cycle t+1.
- R10: After reset, `pred_bits` equals 1, meaning only predicate 0 is set, and all write enables are low.
- R11: Opcodes 6 and 7 cause no writeback and no predicate change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Always 1; the unit accepts every cycle |
| in_op | input | 3 | Opcode (see R2, R6, R11) |
| in_qp | input | 6 | Qualifying predicate index |
| in_src1_idx | input | 7 | First source register index |
| in_src1_val | input | 64 | First source value |
| in_src2_idx | input | 7 | Second source register index |
| in_src2_val | input | 64 | Second source value |
| in_imm | input | 64 | Immediate operand |
| in_use_imm | input | 1 | Use the immediate instead of the second source |
| in_dst | input | 7 | Destination general register |
| in_pdst1 | input | 6 | Predicate that receives the condition |
| in_pdst2 | input | 6 | Predicate that receives the inverse condition |
| gr_we | output | 1 | General register write enable |
| gr_waddr | output | 7 | General register write index |
| gr_wdata | output | 64 | General register write data |
| pr_we1 | output | 1 | First predicate write enable |
| pr_waddr1 | output | 6 | First predicate write index |
| pr_wdata1 | output | 1 | First predicate write value |
| pr_we2 | output | 1 | Second predicate write enable |
| pr_waddr2 | output | 6 | Second predicate write index |
| pr_wdata2 | output | 1 | Second predicate write value |
| pred_bits | output | 64 | Current state of all predicate registers |

## Verification
The directed stimulus sets the signed and unsigned less-than opcodes against the same pair of operands, one all-ones and one small positive. Only the two opcodes' disagreement shows that signedness is handled correctly. Two operations are issued back to back, with a compare guarding its successor under true and under false predicates. This separates a correct same-edge predicate update from a stale read, and it shows that a false guard also freezes compares. Aliased, zero-indexed and reserved-opcode cases each receive their own pattern. A long random stream then draws indices from a small pool, so that aliasing, register 0 and freshly written predicates occur often. A behavioural model checks that stream on every clock.

// File: rtl/pce_pkg.sv
`timescale 1ns/1ps
package pce_pkg;
  parameter int XLEN_DEF  = 64;
  parameter int NPRED_DEF = 64;
  parameter int NGPR_DEF  = 128;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CEQ  = 3'd2,
    OP_CNE  = 3'd3,
    OP_CLT  = 3'd4,
    OP_CLTU = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;
endpackage

// File: rtl/pce_operand_sel.sv
`timescale 1ns/1ps
module pce_operand_sel #(
  parameter int XLEN = 64,
  parameter int GAW  = 7
) (
  input  logic [GAW-1:0]  src1_idx,
  input  logic [XLEN-1:0] src1_val,
  input  logic [GAW-1:0]  src2_idx,
  input  logic [XLEN-1:0] src2_val,
  input  logic [XLEN-1:0] imm,
  input  logic            use_imm,
  output logic [XLEN-1:0] opa,
  output logic [XLEN-1:0] opb
);
  logic [XLEN-1:0] src2_eff;

  // register 0 is a constant zero regardless of what the read port shows
  always_comb begin
    opa      = (src1_idx == '0) ? '0 : src1_val;
    src2_eff = (src2_idx == '0) ? '0 : src2_val;
    opb      = use_imm ? imm : src2_eff;
  end
endmodule

// File: rtl/pce_alu.sv
`timescale 1ns/1ps
module pce_alu
  import pce_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] result,
  output logic            cond,
  output logic            is_arith,
  output logic            is_cmp
);
  op_e             op_dec;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] diff;
  logic            eq;
  logic            lt_s;
  logic            lt_u;

  always_comb begin
    op_dec = op_e'(op);
    sum    = opa + opb;
    diff   = opa - opb;
    eq     = (opa == opb);
    lt_u   = (opa < opb);
    lt_s   = ($signed(opa) < $signed(opb));

    result   = sum;
    cond     = 1'b0;
    is_arith = 1'b0;
    is_cmp   = 1'b0;
    unique case (op_dec)
      OP_ADD:  begin is_arith = 1'b1; result = sum;  end
      OP_SUB:  begin is_arith = 1'b1; result = diff; end
      OP_CEQ:  begin is_cmp = 1'b1; cond = eq;   end
      OP_CNE:  begin is_cmp = 1'b1; cond = !eq;  end
      OP_CLT:  begin is_cmp = 1'b1; cond = lt_s; end
      OP_CLTU: begin is_cmp = 1'b1; cond = lt_u; end
      default: begin is_arith = 1'b0; is_cmp = 1'b0; end
    endcase
  end
endmodule

// File: rtl/pce_pred_file.sv
`timescale 1ns/1ps
module pce_pred_file #(
  parameter int NPRED = 64,
  parameter int PAW   = $clog2(NPRED)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we1,
  input  logic [PAW-1:0]   waddr1,
  input  logic             wdata1,
  input  logic             we2,
  input  logic [PAW-1:0]   waddr2,
  input  logic             wdata2,
  input  logic [PAW-1:0]   raddr,
  output logic             rdata,
  output logic [NPRED-1:0] bits
);
  for (genvar g = 0; g < NPRED; g++) begin : g_bit
    if (g == 0) begin : g_const
      assign bits[g] = 1'b1;
    end else begin : g_flop
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= 1'b0;
        else if (we1 && (waddr1 == PAW'(g)))
          q <= wdata1;      // first destination wins on alias
        else if (we2 && (waddr2 == PAW'(g)))
          q <= wdata2;
      end
      assign bits[g] = q;
    end
  end

  assign rdata = bits[raddr];
endmodule

// File: rtl/pce_unit.sv
`timescale 1ns/1ps
module pce_unit #(
  parameter int XLEN  = pce_pkg::XLEN_DEF,
  parameter int NPRED = pce_pkg::NPRED_DEF,
  parameter int NGPR  = pce_pkg::NGPR_DEF,
  localparam int PAW  = $clog2(NPRED),
  localparam int GAW  = $clog2(NGPR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [PAW-1:0]   in_qp,
  input  logic [GAW-1:0]   in_src1_idx,
  input  logic [XLEN-1:0]  in_src1_val,
  input  logic [GAW-1:0]   in_src2_idx,
  input  logic [XLEN-1:0]  in_src2_val,
  input  logic [XLEN-1:0]  in_imm,
  input  logic             in_use_imm,
  input  logic [GAW-1:0]   in_dst,
  input  logic [PAW-1:0]   in_pdst1,
  input  logic [PAW-1:0]   in_pdst2,
  output logic             gr_we,
  output logic [GAW-1:0]   gr_waddr,
  output logic [XLEN-1:0]  gr_wdata,
  output logic             pr_we1,
  output logic [PAW-1:0]   pr_waddr1,
  output logic             pr_wdata1,
  output logic             pr_we2,
  output logic [PAW-1:0]   pr_waddr2,
  output logic             pr_wdata2,
  output logic [NPRED-1:0] pred_bits
);
  logic [XLEN-1:0] opa, opb, result;
  logic            cond, is_arith, is_cmp;
  logic            qp_true, fire;
  logic            gr_go, p1_go, p2_go;

  assign in_ready = 1'b1;

  pce_operand_sel #(.XLEN(XLEN), .GAW(GAW)) u_opsel (
    .src1_idx (in_src1_idx),
    .src1_val (in_src1_val),
    .src2_idx (in_src2_idx),
    .src2_val (in_src2_val),
    .imm      (in_imm),
    .use_imm  (in_use_imm),
    .opa      (opa),
    .opb      (opb)
  );

  pce_alu #(.XLEN(XLEN)) u_alu (
    .op       (in_op),
    .opa      (opa),
    .opb      (opb),
    .result   (result),
    .cond     (cond),
    .is_arith (is_arith),
    .is_cmp   (is_cmp)
  );

  always_comb begin
    fire  = in_valid && qp_true;
    gr_go = fire && is_arith && (in_dst != '0);
    p1_go = fire && is_cmp && (in_pdst1 != '0);
    p2_go = fire && is_cmp && (in_pdst2 != '0) && (in_pdst2 != in_pdst1);
  end

  pce_pred_file #(.NPRED(NPRED), .PAW(PAW)) u_pfile (
    .clk    (clk),
    .rst_n  (rst_n),
    .we1    (p1_go),
    .waddr1 (in_pdst1),
    .wdata1 (cond),
    .we2    (p2_go),
    .waddr2 (in_pdst2),
    .wdata2 (!cond),
    .raddr  (in_qp),
    .rdata  (qp_true),
    .bits   (pred_bits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gr_we     <= 1'b0;
      gr_waddr  <= '0;
      gr_wdata  <= '0;
      pr_we1    <= 1'b0;
      pr_waddr1 <= '0;
      pr_wdata1 <= 1'b0;
      pr_we2    <= 1'b0;
      pr_waddr2 <= '0;
      pr_wdata2 <= 1'b0;
    end else begin
      gr_we     <= gr_go;
      gr_waddr  <= in_dst;
      gr_wdata  <= result;
      pr_we1    <= p1_go;
      pr_waddr1 <= in_pdst1;
      pr_wdata1 <= cond;
      pr_we2    <= p2_go;
      pr_waddr2 <= in_pdst2;
      pr_wdata2 <= !cond;
    end
  end
endmodule

// File: rtl/pce_unit_checker.sv
`timescale 1ns/1ps
module pce_unit_checker #(
  parameter int NPRED = 64,
  parameter int GAW   = 7,
  localparam int PAW  = $clog2(NPRED)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             gr_we,
  input logic [GAW-1:0]   gr_waddr,
  input logic             pr_we1,
  input logic [PAW-1:0]   pr_waddr1,
  input logic             pr_wdata1,
  input logic             pr_we2,
  input logic [PAW-1:0]   pr_waddr2,
  input logic             pr_wdata2,
  input logic [NPRED-1:0] pred_bits
);
  assert_p0_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pred_bits[0] == 1'b1);

  assert_no_r0_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gr_we |-> (gr_waddr != '0));

  assert_no_p0_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_we1 || pr_we2) |-> ((!pr_we1 || pr_waddr1 != '0) && (!pr_we2 || pr_waddr2 != '0)));

  assert_pair_inverse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_we1 && pr_we2) |-> (pr_wdata2 != pr_wdata1));

  assert_alias_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pr_we2 |-> !(pr_we1 && (pr_waddr1 == pr_waddr2)));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!gr_we && !pr_we1 && !pr_we2));

  assert_pred_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pr_we1 && !pr_we2) |-> $stable(pred_bits));

  assert_pred_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pr_we1 |-> (pred_bits[pr_waddr1] == pr_wdata1));

  assert_kind_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    gr_we |-> (!pr_we1 && !pr_we2));
endmodule

bind pce_unit pce_unit_checker #(.NPRED(NPRED), .GAW(GAW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .gr_we     (gr_we),
  .gr_waddr  (gr_waddr),
  .pr_we1    (pr_we1),
  .pr_waddr1 (pr_waddr1),
  .pr_wdata1 (pr_wdata1),
  .pr_we2    (pr_we2),
  .pr_waddr2 (pr_waddr2),
  .pr_wdata2 (pr_wdata2),
  .pred_bits (pred_bits)
);

// File: tb/pce_unit_tb_top.sv
`timescale 1ns/1ps
module pce_unit_tb_top;
  localparam int XLEN  = 64;
  localparam int NPRED = 64;
  localparam int PAW   = 6;
  localparam int GAW   = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [2:0]       in_op = '0;
  logic [PAW-1:0]   in_qp = '0;
  logic [GAW-1:0]   in_src1_idx = '0, in_src2_idx = '0, in_dst = '0;
  logic [XLEN-1:0]  in_src1_val = '0, in_src2_val = '0, in_imm = '0;
  logic             in_use_imm = 1'b0;
  logic [PAW-1:0]   in_pdst1 = '0, in_pdst2 = '0;
  logic             gr_we, pr_we1, pr_we2, pr_wdata1, pr_wdata2;
  logic [GAW-1:0]   gr_waddr;
  logic [XLEN-1:0]  gr_wdata;
  logic [PAW-1:0]   pr_waddr1, pr_waddr2;
  logic [NPRED-1:0] pred_bits;

  pce_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_qp(in_qp),
    .in_src1_idx(in_src1_idx), .in_src1_val(in_src1_val),
    .in_src2_idx(in_src2_idx), .in_src2_val(in_src2_val),
    .in_imm(in_imm), .in_use_imm(in_use_imm), .in_dst(in_dst),
    .in_pdst1(in_pdst1), .in_pdst2(in_pdst2),
    .gr_we(gr_we), .gr_waddr(gr_waddr), .gr_wdata(gr_wdata),
    .pr_we1(pr_we1), .pr_waddr1(pr_waddr1), .pr_wdata1(pr_wdata1),
    .pr_we2(pr_we2), .pr_waddr2(pr_waddr2), .pr_wdata2(pr_wdata2),
    .pred_bits(pred_bits)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state
  bit [NPRED-1:0] m_pred;
  bit             e_gwe, e_p1we, e_p2we, e_p1d, e_p2d;
  bit [GAW-1:0]   e_gaddr;
  bit [XLEN-1:0]  e_gdata;
  bit [PAW-1:0]   e_p1a, e_p2a;
  string          e_tag = "R10";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_now();
    chk(in_ready === 1'b1, "R1", "in_ready", 64'(in_ready), 64'd1);
    chk(gr_we === e_gwe, e_tag, "gr_we", 64'(gr_we), 64'(e_gwe));
    if (e_gwe) begin
      chk(gr_waddr === e_gaddr, e_tag, "gr_waddr", 64'(gr_waddr), 64'(e_gaddr));
      chk(gr_wdata === e_gdata, e_tag, "gr_wdata", gr_wdata, e_gdata);
    end
    chk(pr_we1 === e_p1we, e_tag, "pr_we1", 64'(pr_we1), 64'(e_p1we));
    if (e_p1we) begin
      chk(pr_waddr1 === e_p1a, e_tag, "pr_waddr1", 64'(pr_waddr1), 64'(e_p1a));
      chk(pr_wdata1 === e_p1d, e_tag, "pr_wdata1", 64'(pr_wdata1), 64'(e_p1d));
    end
    chk(pr_we2 === e_p2we, e_tag, "pr_we2", 64'(pr_we2), 64'(e_p2we));
    if (e_p2we) begin
      chk(pr_waddr2 === e_p2a, e_tag, "pr_waddr2", 64'(pr_waddr2), 64'(e_p2a));
      chk(pr_wdata2 === e_p2d, e_tag, "pr_wdata2", 64'(pr_wdata2), 64'(e_p2d));
    end
    chk(pred_bits === m_pred, e_tag, "pred_bits", pred_bits, m_pred);
  endtask

  // apply one cycle of stimulus at a falling edge, after checking the last one
  task automatic issue(input bit v, input bit [2:0] op, input bit [PAW-1:0] qp,
                       input bit [GAW-1:0] s1i, input bit [63:0] s1v,
                       input bit [GAW-1:0] s2i, input bit [63:0] s2v,
                       input bit [63:0] imm, input bit ui, input bit [GAW-1:0] dst,
                       input bit [PAW-1:0] pd1, input bit [PAW-1:0] pd2,
                       input string tag);
    bit [63:0] a, b, r;
    bit c, arith, cmpop, qok;
    @(negedge clk);
    compare_now();
    in_valid = v; in_op = op; in_qp = qp;
    in_src1_idx = s1i; in_src1_val = s1v; in_src2_idx = s2i; in_src2_val = s2v;
    in_imm = imm; in_use_imm = ui; in_dst = dst; in_pdst1 = pd1; in_pdst2 = pd2;
    a = (s1i == 0) ? 64'd0 : s1v;
    b = ui ? imm : ((s2i == 0) ? 64'd0 : s2v);
    qok = m_pred[qp];
    arith = 0; cmpop = 0; c = 0; r = 0;
    case (op)
      3'd0: begin arith = 1; r = a + b; end
      3'd1: begin arith = 1; r = a - b; end
      3'd2: begin cmpop = 1; c = (a == b); end
      3'd3: begin cmpop = 1; c = (a != b); end
      3'd4: begin cmpop = 1; c = ($signed(a) < $signed(b)); end
      3'd5: begin cmpop = 1; c = (a < b); end
      default: ;
    endcase
    e_tag  = tag;
    e_gwe  = v && qok && arith && (dst != 0);
    e_gaddr = dst; e_gdata = r;
    e_p1we = v && qok && cmpop && (pd1 != 0);
    e_p2we = v && qok && cmpop && (pd2 != 0) && (pd2 != pd1);
    e_p1a = pd1; e_p1d = c; e_p2a = pd2; e_p2d = !c;
    if (e_p2we) m_pred[pd2] = !c;
    if (e_p1we) m_pred[pd1] = c;
    m_pred[0] = 1'b1;
  endtask

  task automatic idle(input string tag);
    issue(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_pred = 64'd1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // reset state, R10 (compared by the first issue call)
    e_tag = "R10"; e_gwe = 0; e_p1we = 0; e_p2we = 0;
    // R2 add register+register, add immediate, subtract wrap
    issue(1, 3'd0, 0, 5, 64'd100, 6, 64'd23, 0, 0, 7, 0, 0, "R2");
    issue(1, 3'd0, 0, 5, 64'd100, 6, 64'd23, 64'hFFFF_FFFF_FFFF_FFFF, 1, 8, 0, 0, "R2");
    issue(1, 3'd1, 0, 5, 64'd3, 6, 64'd5, 0, 0, 9, 0, 0, "R2");
    // R3 register 0 reads zero on both sources
    issue(1, 3'd0, 0, 0, 64'hDEAD, 0, 64'hBEEF, 0, 0, 10, 0, 0, "R3");
    // R8 write to r0 suppressed
    issue(1, 3'd0, 0, 5, 64'd1, 6, 64'd1, 0, 0, 0, 0, 0, "R8");
    // R5/R6 equal and not-equal compares
    issue(1, 3'd2, 0, 5, 64'd42, 6, 64'd42, 0, 0, 0, 1, 2, "R5");
    issue(1, 3'd3, 0, 5, 64'd42, 0, 64'd0, 0, 0, 0, 3, 4, "R6");
    // R6 signed vs unsigned on all-ones against one
    issue(1, 3'd4, 0, 5, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 64'd1, 1, 0, 5, 6, "R6");
    issue(1, 3'd5, 0, 5, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 64'd1, 1, 0, 7, 8, "R6");
    // R9 back-to-back: p5 was just set true, p6 false
    issue(1, 3'd0, 5, 5, 64'd9, 6, 64'd1, 0, 0, 11, 0, 0, "R9");
    issue(1, 3'd0, 6, 5, 64'd9, 6, 64'd1, 0, 0, 12, 0, 0, "R4");
    // R4 compare under false predicate leaves targets alone
    issue(1, 3'd2, 6, 5, 64'd1, 6, 64'd1, 0, 0, 0, 5, 6, "R4");
    // compare sets p9 false then guards next op
    issue(1, 3'd2, 0, 5, 64'd1, 6, 64'd2, 0, 0, 0, 9, 10, "R9");
    issue(1, 3'd2, 9, 5, 64'd1, 6, 64'd1, 0, 0, 0, 11, 12, "R9");
    // R7 aliased destinations: first wins
    issue(1, 3'd3, 0, 5, 64'd1, 6, 64'd2, 0, 0, 0, 13, 13, "R7");
    issue(1, 3'd2, 0, 5, 64'd1, 6, 64'd2, 0, 0, 0, 13, 13, "R7");
    // R8 predicate 0 as destination
    issue(1, 3'd2, 0, 5, 64'd1, 6, 64'd2, 0, 0, 0, 0, 14, "R8");
    // R11 reserved opcodes
    issue(1, 3'd6, 0, 5, 64'd1, 6, 64'd1, 0, 0, 15, 15, 16, "R11");
    issue(1, 3'd7, 0, 5, 64'd1, 6, 64'd1, 0, 0, 15, 15, 16, "R11");
    // R1 idle cycle with garbage fields
    issue(0, 3'd0, 0, 5, 64'd1, 6, 64'd1, 0, 0, 15, 15, 16, "R1");
    // random stream
    for (int i = 0; i < 400; i++) begin
      issue(($urandom % 8) != 0, 3'($urandom), PAW'($urandom % 8),
            GAW'($urandom % 4), {$urandom, $urandom},
            GAW'($urandom % 4), (($urandom % 3) == 0) ? 64'd7 : {$urandom, $urandom},
            (($urandom % 2) == 0) ? 64'd7 : {$urandom, $urandom}, 1'($urandom),
            GAW'($urandom % 4), PAW'($urandom % 8), PAW'($urandom % 8), "R2");
    end
    idle("R1");
    idle("R1");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule